// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block is the trap-entry and trap-return logic of a small 32-bit processor. Two request ports feed it, one for normal-class exceptions and one for debug-class exceptions, each carrying a 3-bit cause code. On the clock edge that accepts a request, the block does three things at once. It saves the current program counter into the link register of that class, and it copies the global interrupt enable into the saved-enable bit of that class. It also clears the global enable. On the next cycle it presents a program-counter redirect for the fetch stage.

The redirect target is a base address plus the cause code times 32, so each vector slot is 32 bytes. Debug-class traps always use the debug base. Normal-class traps use the normal base, or the debug base when the remap bit is set. A cause code that does not belong to the class of its port is not vectored. It raises an unhandled-exception pulse instead and changes no state.

Two return strobes restore the global enable from the saved bit of their class and redirect to that class's link register. While reset is held, and on the first cycle after it, the block also requests a redirect to the normal base.

Top module: `trap_entry`

## Requirements
- R1: While reset is asserted, and until the first rising clock edge after its release, `redir_valid` is 1 and `redir_pc` equals `normal_base`. Reset clears `gie`, `nsave`, `dsave`, `remap`, `nret_pc` and `dret_pc` to zero.
- R2: A normal trap is accepted when `norm_req` is high, `norm_cause` is 2, 4, 5, 6 or 7, and `dbg_req` is low. On that edge `nret_pc` takes `cur_pc`, `nsave` takes `gie`, and `gie` becomes 0. `dret_pc` and `dsave` are left unchanged.
- R3: A debug trap is accepted when `dbg_req` is high and `dbg_cause` is 1 or 3. On that edge `dret_pc` takes `cur_pc`, `dsave` takes `gie`, and `gie` becomes 0. `nret_pc` and `nsave` are left unchanged.
- R4: In the cycle after an accepted trap, `redir_valid` is 1 and `redir_pc` is the selected base plus the cause times 32. `redir_valid` then falls after one cycle unless a new request arrives.
- R5: A normal trap vectors from `debug_base` when the stored `remap` bit is 1, and from `normal_base` when it is 0.
- R6: A debug trap always vectors from `debug_base`, whatever the value of `remap`.
- R7: A request with an illegal cause for its port raises `unhandled` for one cycle. Illegal causes are 0, 1 and 3 on the normal port, and 0, 2, 4, 5, 6 and 7 on the debug port. Such a request gives no redirect and leaves `gie`, `nsave`, `dsave`, `nret_pc` and `dret_pc` unchanged.
- R8: `nreturn`, with no trap request present, copies `nsave` into `gie` and gives a redirect to `nret_pc` in the next cycle.
- R9: `dreturn`, with no trap request present, copies `dsave` into `gie` and gives a redirect to `dret_pc` in the next cycle. It takes precedence over `nreturn`.
- R10: When both ports request in the same cycle, only the debug request is acted on and the normal request is dropped. A trap request overrides both return strobes and a `gie` write in the same cycle.
- R11: `gie_we` loads `gie_wdata` into `gie` when no trap or return is taken. `remap_we` always loads `remap_wdata` into `remap`. A trap in the same cycle uses the old `remap` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc | input | XLEN | PC of the instruction taking the trap |
| normal_base | input | XLEN | Vector base for normal traps |
| debug_base | input | XLEN | Vector base for debug traps |
| norm_req | input | 1 | Normal-class trap request |
| norm_cause | input | CW | Cause code of the normal request |
| dbg_req | input | 1 | Debug-class trap request |
| dbg_cause | input | CW | Cause code of the debug request |
| nreturn | input | 1 | Return from a normal trap |
| dreturn | input | 1 | Return from a debug trap |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wdata | input | 1 | Global enable write value |
| remap_we | input | 1 | Write strobe for the remap bit |
| remap_wdata | input | 1 | Remap bit write value |
| redir_valid | output | 1 | Redirect request to fetch |
| redir_pc | output | XLEN | Redirect target |
| gie | output | 1 | Global interrupt enable |
| nsave | output | 1 | Enable saved on a normal trap |
| dsave | output | 1 | Enable saved on a debug trap |
| remap | output | 1 | Normal traps use the debug base |
| nret_pc | output | XLEN | Normal-class link register |
| dret_pc | output | XLEN | Debug-class link register |
| unhandled | output | 1 | Illegal-cause pulse |

## Verification
Every piece of state in this block drives a port directly. A wrong link register, saved-enable bit or global enable is therefore visible one cycle after the edge that corrupts it. It shows again later as a wrong redirect target or a wrong restored enable when the matching return is issued. A wrong remap bit or base selection shows as a wrong `redir_pc` in the cycle right after the trap. The bench reads the link registers and enables directly after each trap and after each return. This catches a misrouted class, a swapped saved bit or a missed clear before the next stimulus.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int XLEN       = 32,
  parameter int CW         = 3,
  parameter int SLOT_SHIFT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] normal_base,
  input  logic [XLEN-1:0] debug_base,
  input  logic            norm_req,
  input  logic [CW-1:0]   norm_cause,
  input  logic            dbg_req,
  input  logic [CW-1:0]   dbg_cause,
  input  logic            nreturn,
  input  logic            dreturn,
  input  logic            gie_we,
  input  logic            gie_wdata,
  input  logic            remap_we,
  input  logic            remap_wdata,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            gie,
  output logic            nsave,
  output logic            dsave,
  output logic            remap,
  output logic [XLEN-1:0] nret_pc,
  output logic [XLEN-1:0] dret_pc,
  output logic            unhandled
);

  localparam logic [CW-1:0] C_BREAK = CW'(1);
  localparam logic [CW-1:0] C_IBUS  = CW'(2);
  localparam logic [CW-1:0] C_WATCH = CW'(3);
  localparam logic [CW-1:0] C_DBUS  = CW'(4);
  localparam logic [CW-1:0] C_DIV0  = CW'(5);
  localparam logic [CW-1:0] C_IRQ   = CW'(6);
  localparam logic [CW-1:0] C_SCALL = CW'(7);

  logic            boot_q, rv_q, err_q;
  logic [XLEN-1:0] pc_q;

  wire dbg_ok  = (dbg_cause == C_BREAK) || (dbg_cause == C_WATCH);
  wire norm_ok = (norm_cause == C_IBUS) || (norm_cause == C_DBUS) ||
                 (norm_cause == C_DIV0) || (norm_cause == C_IRQ)  ||
                 (norm_cause == C_SCALL);

  wire dbg_take  = dbg_req & dbg_ok;
  wire norm_take = norm_req & norm_ok & ~dbg_req;
  wire bad_req   = dbg_req ? ~dbg_ok : (norm_req & ~norm_ok);
  wire any_req   = dbg_req | norm_req;
  wire do_dret   = dreturn & ~any_req;
  wire do_nret   = nreturn & ~dreturn & ~any_req;

  wire [CW-1:0]   sel_cause = dbg_req ? dbg_cause : norm_cause;
  wire [XLEN-1:0] vec_base  = (dbg_take | remap) ? debug_base : normal_base;
  wire [XLEN-1:0] vec_pc    = vec_base + (XLEN'(sel_cause) << SLOT_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q  <= 1'b1;
      rv_q    <= 1'b0;
      err_q   <= 1'b0;
      pc_q    <= '0;
      gie     <= 1'b0;
      nsave   <= 1'b0;
      dsave   <= 1'b0;
      remap   <= 1'b0;
      nret_pc <= '0;
      dret_pc <= '0;
    end else begin
      boot_q <= 1'b0;
      rv_q   <= dbg_take | norm_take | do_dret | do_nret;
      err_q  <= bad_req;
      if (remap_we) remap <= remap_wdata;
      if (dbg_take) begin
        dret_pc <= cur_pc;
        dsave   <= gie;
        gie     <= 1'b0;
        pc_q    <= vec_pc;
      end else if (norm_take) begin
        nret_pc <= cur_pc;
        nsave   <= gie;
        gie     <= 1'b0;
        pc_q    <= vec_pc;
      end else if (do_dret) begin
        gie  <= dsave;
        pc_q <= dret_pc;
      end else if (do_nret) begin
        gie  <= nsave;
        pc_q <= nret_pc;
      end else if (gie_we && !any_req) begin
        gie <= gie_wdata;
      end
    end
  end

  assign redir_valid = boot_q | rv_q;
  assign redir_pc    = boot_q ? normal_base : pc_q;
  assign unhandled   = err_q;

  assert_norm_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
    norm_take |=> (nret_pc == $past(cur_pc)) && (nsave == $past(gie)) && !gie
                  && $stable(dret_pc) && $stable(dsave));

  assert_dbg_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> (dret_pc == $past(cur_pc)) && (dsave == $past(gie)) && !gie
                 && $stable(nret_pc) && $stable(nsave));

  assert_dbg_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> redir_valid && (redir_pc - $past(debug_base) == XLEN'($past(dbg_cause)) << SLOT_SHIFT));

  assert_bad_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |=> unhandled && !rv_q && $stable(gie) && $stable(nret_pc) && $stable(dret_pc));

  assert_nret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_nret |=> (gie == $past(nsave)) && rv_q && (redir_pc == $past(nret_pc)));

  assert_dret_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_dret |=> (gie == $past(dsave)) && rv_q && (redir_pc == $past(dret_pc)));

  assert_excl_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rv_q, err_q}));

endmodule

// File: tb/sim_trap_entry.sv
module sim_trap_entry;
  localparam int XLEN = 32;
  localparam int CW   = 3;
  localparam logic [XLEN-1:0] NB = 32'h0000_4000;
  localparam logic [XLEN-1:0] DB = 32'h0008_0000;
  localparam int NV = 11;
  // bits: [5] gie, [4] remap, [3] port (1 = debug), [2:0] cause
  localparam logic [5:0] VEC [0:NV-1] = '{6'h22, 6'h06, 6'h37, 6'h29, 6'h1B,
                                          6'h20, 6'h21, 6'h3D, 6'h24, 6'h05, 6'h3B};

  logic clk = 0, rst_n = 0;
  logic [XLEN-1:0] cur_pc = 0, normal_base = NB, debug_base = DB;
  logic norm_req = 0, dbg_req = 0, nreturn = 0, dreturn = 0;
  logic [CW-1:0] norm_cause = 0, dbg_cause = 0;
  logic gie_we = 0, gie_wdata = 0, remap_we = 0, remap_wdata = 0;
  logic redir_valid, gie, nsave, dsave, remap, unhandled;
  logic [XLEN-1:0] redir_pc, nret_pc, dret_pc;

  int checks = 0, errors = 0;
  logic done = 0;
  logic [XLEN-1:0] m_nret = 0, m_dret = 0;
  logic m_nsave = 0, m_dsave = 0;

  always #5 clk = ~clk;

  trap_entry #(.XLEN(XLEN), .CW(CW)) u0 (
    .clk, .rst_n, .cur_pc, .normal_base, .debug_base,
    .norm_req, .norm_cause, .dbg_req, .dbg_cause, .nreturn, .dreturn,
    .gie_we, .gie_wdata, .remap_we, .remap_wdata,
    .redir_valid, .redir_pc, .gie, .nsave, .dsave, .remap,
    .nret_pc, .dret_pc, .unhandled);

  task automatic chk(input string tag, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr_state(input logic g, input logic r);
    gie_we = 1; gie_wdata = g; remap_we = 1; remap_wdata = r;
    @(negedge clk);
    gie_we = 0; remap_we = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk("R1", "reset redir_valid", 32'(redir_valid), 1);
    chk("R1", "reset redir_pc", redir_pc, NB);
    chk("R1", "reset enables", {28'd0, gie, nsave, dsave, remap}, 0);
    chk("R1", "reset links", nret_pc | dret_pc, 0);
    @(negedge clk); rst_n = 1;
    chk("R1", "boot redirect held", 32'(redir_valid), 1);
    @(negedge clk);
    chk("R1", "boot redirect dropped", 32'(redir_valid), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic g, r, p, ok;
      logic [CW-1:0] c;
      logic [XLEN-1:0] pc, exp_pc;
      g = VEC[i][5]; r = VEC[i][4]; p = VEC[i][3]; c = VEC[i][2:0];
      pc = 32'h1000 + 32'(i) * 4;
      ok = p ? (c == 1 || c == 3) : (c == 2 || c == 4 || c == 5 || c == 6 || c == 7);
      exp_pc = ((p || r) ? DB : NB) + (32'(c) << 5);
      wr_state(g, r);
      cur_pc = pc;
      if (p) begin dbg_req = 1; dbg_cause = c; end
      else begin norm_req = 1; norm_cause = c; end
      @(negedge clk);
      dbg_req = 0; norm_req = 0;
      if (ok) begin
        if (p) begin m_dret = pc; m_dsave = g; end
        else begin m_nret = pc; m_nsave = g; end
        chk(p ? "R3" : "R2", "gie cleared", 32'(gie), 0);
        chk("R4", "redir_valid", 32'(redir_valid), 1);
        chk(p ? "R6" : "R5", "vector pc", redir_pc, exp_pc);
        chk("R7", "no unhandled", 32'(unhandled), 0);
      end else begin
        chk("R7", "unhandled", 32'(unhandled), 1);
        chk("R7", "no redirect", 32'(redir_valid), 0);
        chk("R7", "gie kept", 32'(gie), 32'(g));
      end
      chk(p ? "R3" : "R2", "nret_pc", nret_pc, m_nret);
      chk(p ? "R3" : "R2", "dret_pc", dret_pc, m_dret);
      chk(p ? "R3" : "R2", "nsave", 32'(nsave), 32'(m_nsave));
      chk(p ? "R3" : "R2", "dsave", 32'(dsave), 32'(m_dsave));
      @(negedge clk);
      chk("R4", "redirect one cycle", 32'(redir_valid | unhandled), 0);
    end

    // both ports at once: debug wins (R10)
    wr_state(1, 0);
    cur_pc = 32'h2000; norm_req = 1; norm_cause = 6; dbg_req = 1; dbg_cause = 1;
    @(negedge clk);
    norm_req = 0; dbg_req = 0;
    chk("R10", "debug wins pc", redir_pc, DB + 32);
    chk("R10", "dret_pc", dret_pc, 32'h2000);
    chk("R10", "nret_pc untouched", nret_pc, m_nret);
    chk("R10", "dsave", 32'(dsave), 1);

    // normal trap then normal return (R8)
    wr_state(1, 0);
    cur_pc = 32'h3000; norm_req = 1; norm_cause = 5;
    @(negedge clk);
    norm_req = 0;
    chk("R8", "gie cleared before return", 32'(gie), 0);
    nreturn = 1;
    @(negedge clk);
    nreturn = 0;
    chk("R8", "gie restored", 32'(gie), 1);
    chk("R8", "return redirect", redir_pc, 32'h3000);
    chk("R8", "return valid", 32'(redir_valid), 1);

    // debug return outranks normal return (R9); dsave still 1 from above
    wr_state(0, 0);
    dreturn = 1; nreturn = 1;
    @(negedge clk);
    dreturn = 0; nreturn = 0;
    chk("R9", "gie from dsave", 32'(gie), 1);
    chk("R9", "return to dret_pc", redir_pc, 32'h2000);

    // trap overrides return and gie write (R10, R11)
    wr_state(1, 0);
    cur_pc = 32'h4444; norm_req = 1; norm_cause = 2; nreturn = 1; gie_we = 1; gie_wdata = 1;
    @(negedge clk);
    norm_req = 0; nreturn = 0; gie_we = 0;
    chk("R10", "trap beats gie write", 32'(gie), 0);
    chk("R10", "trap beats return", redir_pc, NB + 64);

    // plain gie writes; remap write uses old value on same-cycle trap (R11)
    gie_we = 1; gie_wdata = 1;
    @(negedge clk);
    gie_we = 0;
    chk("R11", "gie write 1", 32'(gie), 1);
    chk("R11", "idle no redirect", 32'(redir_valid), 0);
    remap_we = 1; remap_wdata = 1; norm_req = 1; norm_cause = 7;
    @(negedge clk);
    remap_we = 0; norm_req = 0;
    chk("R11", "old remap used", redir_pc, NB + 224);
    chk("R11", "remap written", 32'(remap), 1);
    gie_we = 1; gie_wdata = 0;
    @(negedge clk);
    gie_we = 0;
    chk("R11", "gie write 0", 32'(gie), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule